// File: doc/BRIEF.md
# Test Coprocessor with Timed Interrupts

This block sits beside a host core as an attached coprocessor and answers commands addressed to two coprocessor numbers: a main number (4) and an auxiliary number (5). It holds a file of sixteen 32-bit registers that the core moves values into and out of. The main number also accepts memory load and store transfers, either as single words or as long bursts. The core uses it to exercise its own handshake paths: stalls of a programmed length, interrupts that fire after a programmed delay, and timestamps taken from a free-running cycle counter.

Each command is given for one or more cycles on a simple command port. It carries the coprocessor number, a command kind, a 32-bit instruction word holding the fields, a write-data word and a flag that marks the first cycle of a data operation. The block answers in the same cycle with a response code and read data. Data operations select a function through the opcode field. Opcode 0 stalls the core. Opcodes 1 and 2 arm a countdown that pulls the active-low fast (`fiq_n`) or normal (`irq_n`) interrupt line low. Opcodes 3 and 4 let those lines go high again. Opcode 5 copies the cycle count into a register. Commands for any other coprocessor number get no response and change nothing.

Top module: `cp_timer_unit`

## Requirements
- R1: Response codes are 0 none, 1 done, 2 busy, 3 cannot, 4 more. After reset, with no command, the response is 0, `fiq_n` and `irq_n` are high and every register reads zero.
- R2: Command kind 0 writes `cmd_wdata` into the register indexed by instruction bits 19:16. Kind 1 returns that register on `rsp_rdata` in the same cycle. Both work on numbers 4 and 5 and answer done.
- R3: Kinds 2 (load start) and 3 (store start) answer done on number 4. Kind 4 (load word) writes `cmd_wdata` to the register indexed by bits 15:12. Kind 5 (store word) returns that register. With bit 22 clear, each word answers done.
- R4: With bit 22 set, each load or store word uses the same register and answers more, until the fifth word of the transfer, which answers done.
- R5: A load start or store start clears the word counter, so a burst that follows it again needs five words to reach done, whatever words came before.
- R6: Kind 6 is a data operation, with the opcode in bits 23:20 and an operand register in bits 3:0. Opcode 0, on either number, answers busy on its first cycle when the operand register holds D>0, then busy on retries until the cycle count reaches the first cycle's count plus D, then done. D=0 answers done at once.
- R7: On number 5, opcode 1 with operand value D drives `fiq_n` low at the D-th clock edge after the command edge. D=0 drives it low at the command edge itself. Opcode 2 does the same for `irq_n`.
- R8: On number 5, opcodes 3 and 4 drive `fiq_n` and `irq_n` high at the command edge. They do not cancel a pending countdown.
- R9: A new schedule command for a line replaces that line's pending countdown.
- R10: On number 5, opcode 5 answers done and writes the cycle count seen in the command cycle into the register indexed by bits 3:0.
- R11: The response is cannot for opcodes 1–15 on number 4, opcodes 6–15 on number 5, kinds 2–5 on number 5, and kind 7 on either number. Such a command changes no line.
- R12: A command for any number other than 4 or 5 gets response 0 and changes no register and no line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A command is present this cycle |
| cmd_cp | input | 4 | Coprocessor number addressed |
| cmd_kind | input | 3 | Command kind (0–7) |
| cmd_instr | input | 32 | Instruction word carrying the fields |
| cmd_wdata | input | 32 | Register-write or load data word |
| cmd_first | input | 1 | First cycle of a data operation |
| cycle_cnt | input | 32 | Free-running cycle count |
| rsp_code | output | 3 | Response code |
| rsp_rdata | output | 32 | Register-read or store data word |
| fiq_n | output | 1 | Fast interrupt, active low |
| irq_n | output | 1 | Normal interrupt, active low |

## Verification
The bench times every interrupt to the exact edge. An off-by-one countdown would pull the line one cycle early or late. A zero delay handled as a full wrap would never assert the line. A reschedule that fails to reload the counter would fire at the first, shorter deadline. A release that cancels the countdown would keep the line high when it should drop. In bursts it checks that the fifth word, and only the fifth, answers done, and that a new start in the middle of a burst clears the count. Random mixes of commands for foreign numbers and illegal opcodes are followed by a full readback, so a decoder that lets those commands write would show a stale or corrupted register.

// File: rtl/cpt_pkg.sv
`timescale 1ns/1ps
package cpt_pkg;
   typedef enum logic [2:0] {
      RSP_NONE = 3'd0,
      RSP_DONE = 3'd1,
      RSP_BUSY = 3'd2,
      RSP_CANT = 3'd3,
      RSP_MORE = 3'd4
   } cpt_rsp_e;

   typedef enum logic [2:0] {
      K_REG_WR   = 3'd0,
      K_REG_RD   = 3'd1,
      K_LD_START = 3'd2,
      K_ST_START = 3'd3,
      K_LD_WORD  = 3'd4,
      K_ST_WORD  = 3'd5,
      K_DATA_OP  = 3'd6,
      K_RSVD     = 3'd7
   } cpt_kind_e;

   localparam logic [3:0] OPC_STALL    = 4'd0;
   localparam logic [3:0] OPC_FAST_SET = 4'd1;
   localparam logic [3:0] OPC_NORM_SET = 4'd2;
   localparam logic [3:0] OPC_FAST_CLR = 4'd3;
   localparam logic [3:0] OPC_NORM_CLR = 4'd4;
   localparam logic [3:0] OPC_STAMP    = 4'd5;

   localparam int MOVE_IDX_LO = 16;
   localparam int XFER_IDX_LO = 12;
   localparam int OPC_LO      = 20;
   localparam int OPR_IDX_LO  = 0;
   localparam int LONG_BIT    = 22;

   localparam int LINE_FAST = 0;
   localparam int LINE_NORM = 1;
   localparam int N_LINES   = 2;
endpackage

// File: rtl/cpt_regfile.sv
`timescale 1ns/1ps
module cpt_regfile #(
   parameter int DATA_W = 32,
   parameter int NREG   = 16,
   localparam int IDX_W = $clog2(NREG)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [IDX_W-1:0]  waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [IDX_W-1:0]  raddr_a,
   output logic [DATA_W-1:0] rdata_a,
   input  logic [IDX_W-1:0]  raddr_b,
   output logic [DATA_W-1:0] rdata_b
);
   logic [DATA_W-1:0] store_q [NREG];

   for (genvar r = 0; r < NREG; r++) begin : g_entry
      always_ff @(posedge clk) begin
         if (!rst_n)
            store_q[r] <= '0;
         else if (we && waddr == IDX_W'(r))
            store_q[r] <= wdata;
      end
   end

   assign rdata_a = store_q[raddr_a];
   assign rdata_b = store_q[raddr_b];
endmodule

// File: rtl/cpt_stall_unit.sv
`timescale 1ns/1ps
module cpt_stall_unit #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [CNT_W-1:0] now,
   input  logic [CNT_W-1:0] delay,
   output logic             done
);
   logic [CNT_W-1:0] finish_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         finish_q <= '0;
      else if (start)
         finish_q <= now + delay;
   end

   assign done = start ? (delay == '0) : (now >= finish_q);
endmodule

// File: rtl/cpt_irq_timer.sv
`timescale 1ns/1ps
module cpt_irq_timer #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sched,
   input  logic             release_i,
   input  logic [CNT_W-1:0] delay,
   output logic             line_n
);
   logic             pend_q;
   logic [CNT_W-1:0] left_q;
   logic             active_q;
   logic             fire;

   assign fire = sched ? (delay == '0) : (pend_q && left_q == CNT_W'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q   <= 1'b0;
         left_q   <= '0;
         active_q <= 1'b0;
      end else begin
         if (sched) begin
            pend_q <= (delay != '0);
            left_q <= delay;
         end else if (pend_q) begin
            left_q <= left_q - CNT_W'(1);
            if (left_q == CNT_W'(1))
               pend_q <= 1'b0;
         end
         if (release_i)
            active_q <= 1'b0;
         else if (fire)
            active_q <= 1'b1;
      end
   end

   assign line_n = !active_q;
endmodule

// File: rtl/cpt_xfer_ctr.sv
`timescale 1ns/1ps
module cpt_xfer_ctr #(
   parameter int LONG_WORDS = 5,
   localparam int CW = (LONG_WORDS > 1) ? $clog2(LONG_WORDS) : 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic step,
   output logic last
);
   logic [CW-1:0] cnt_q;

   assign last = (cnt_q == CW'(LONG_WORDS - 1));

   always_ff @(posedge clk) begin
      if (!rst_n || clear)
         cnt_q <= '0;
      else if (step)
         cnt_q <= last ? '0 : cnt_q + CW'(1);
   end
endmodule

// File: rtl/cp_timer_unit.sv
`timescale 1ns/1ps
module cp_timer_unit #(
   parameter int DATA_W     = 32,
   parameter int NREG       = 16,
   parameter int CNT_W      = 32,
   parameter int LONG_WORDS = 5,
   parameter int CP_MAIN    = 4,
   parameter int CP_AUX     = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [3:0]        cmd_cp,
   input  logic [2:0]        cmd_kind,
   input  logic [31:0]       cmd_instr,
   input  logic [DATA_W-1:0] cmd_wdata,
   input  logic              cmd_first,
   input  logic [CNT_W-1:0]  cycle_cnt,
   output logic [2:0]        rsp_code,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              fiq_n,
   output logic              irq_n
);
   import cpt_pkg::*;

   localparam int IDX_W = $clog2(NREG);

   if (NREG < 2 || NREG > 16 || (NREG & (NREG - 1)) != 0) begin : g_bad_nreg
      $error("NREG must be a power of two from 2 to 16");
   end
   if (CNT_W > DATA_W || CNT_W < 2) begin : g_bad_cnt
      $error("CNT_W must lie between 2 and DATA_W");
   end
   if (LONG_WORDS < 1) begin : g_bad_long
      $error("LONG_WORDS must be at least 1");
   end
   if (CP_MAIN == CP_AUX || CP_MAIN > 15 || CP_AUX > 15) begin : g_bad_cp
      $error("coprocessor numbers must differ and fit four bits");
   end

   cpt_kind_e        kind;
   cpt_rsp_e         rsp;
   logic [3:0]       opc;
   logic [IDX_W-1:0] idx_move, idx_xfer, idx_opr;
   logic             is_long, hit_main, hit_aux;

   logic              rf_we;
   logic [IDX_W-1:0]  rf_waddr, rf_raddr_a;
   logic [DATA_W-1:0] rf_wdata, rd_a, rd_b;
   logic [CNT_W-1:0]  dly;

   logic stall_start, stall_done;
   logic xfer_clr, xfer_step, xfer_last;
   logic [N_LINES-1:0] sched_v, rel_v, line_v;
   logic unused_bits;

   assign kind     = cpt_kind_e'(cmd_kind);
   assign opc      = cmd_instr[OPC_LO +: 4];
   assign idx_move = cmd_instr[MOVE_IDX_LO +: IDX_W];
   assign idx_xfer = cmd_instr[XFER_IDX_LO +: IDX_W];
   assign idx_opr  = cmd_instr[OPR_IDX_LO +: IDX_W];
   assign is_long  = cmd_instr[LONG_BIT];
   assign hit_main = cmd_valid && cmd_cp == 4'(CP_MAIN);
   assign hit_aux  = cmd_valid && cmd_cp == 4'(CP_AUX);
   assign dly      = rd_b[CNT_W-1:0];
   assign unused_bits = ^{cmd_instr, rd_b};

   always_comb begin
      rsp         = RSP_NONE;
      rsp_rdata   = '0;
      rf_we       = 1'b0;
      rf_waddr    = idx_move;
      rf_wdata    = cmd_wdata;
      rf_raddr_a  = idx_move;
      stall_start = 1'b0;
      xfer_clr    = 1'b0;
      xfer_step   = 1'b0;
      sched_v     = '0;
      rel_v       = '0;
      if (hit_main || hit_aux) begin
         unique case (kind)
            K_REG_WR: begin
               rf_we = 1'b1;
               rsp   = RSP_DONE;
            end
            K_REG_RD: begin
               rsp_rdata = rd_a;
               rsp       = RSP_DONE;
            end
            K_LD_START, K_ST_START: begin
               if (hit_main) begin
                  xfer_clr = 1'b1;
                  rsp      = RSP_DONE;
               end else
                  rsp = RSP_CANT;
            end
            K_LD_WORD, K_ST_WORD: begin
               if (hit_main) begin
                  rf_raddr_a = idx_xfer;
                  rf_waddr   = idx_xfer;
                  if (kind == K_LD_WORD)
                     rf_we = 1'b1;
                  else
                     rsp_rdata = rd_a;
                  xfer_step = is_long;
                  rsp = (is_long && !xfer_last) ? RSP_MORE : RSP_DONE;
               end else
                  rsp = RSP_CANT;
            end
            K_DATA_OP: begin
               rsp = RSP_CANT;
               if (opc == OPC_STALL) begin
                  stall_start = cmd_first;
                  rsp = stall_done ? RSP_DONE : RSP_BUSY;
               end else if (hit_aux) begin
                  rsp = RSP_DONE;
                  case (opc)
                     OPC_FAST_SET: sched_v[LINE_FAST] = 1'b1;
                     OPC_NORM_SET: sched_v[LINE_NORM] = 1'b1;
                     OPC_FAST_CLR: rel_v[LINE_FAST]   = 1'b1;
                     OPC_NORM_CLR: rel_v[LINE_NORM]   = 1'b1;
                     OPC_STAMP: begin
                        rf_we    = 1'b1;
                        rf_waddr = idx_opr;
                        rf_wdata = DATA_W'(cycle_cnt);
                     end
                     default: rsp = RSP_CANT;
                  endcase
               end
            end
            default: rsp = RSP_CANT;
         endcase
      end
   end

   assign rsp_code = rsp;

   cpt_regfile #(.DATA_W(DATA_W), .NREG(NREG)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .we(rf_we), .waddr(rf_waddr), .wdata(rf_wdata),
      .raddr_a(rf_raddr_a), .rdata_a(rd_a),
      .raddr_b(idx_opr), .rdata_b(rd_b)
   );

   cpt_stall_unit #(.CNT_W(CNT_W)) u_stall (
      .clk(clk), .rst_n(rst_n), .start(stall_start),
      .now(cycle_cnt), .delay(dly), .done(stall_done)
   );

   cpt_xfer_ctr #(.LONG_WORDS(LONG_WORDS)) u_xfer (
      .clk(clk), .rst_n(rst_n), .clear(xfer_clr),
      .step(xfer_step), .last(xfer_last)
   );

   for (genvar g = 0; g < N_LINES; g++) begin : g_line
      cpt_irq_timer #(.CNT_W(CNT_W)) u_tmr (
         .clk(clk), .rst_n(rst_n), .sched(sched_v[g]),
         .release_i(rel_v[g]), .delay(dly), .line_n(line_v[g])
      );
   end

   assign fiq_n = line_v[LINE_FAST];
   assign irq_n = line_v[LINE_NORM];
endmodule

// File: rtl/cpt_checker.sv
`timescale 1ns/1ps
module cpt_checker #(
   parameter int DATA_W = 32,
   parameter int CNT_W  = 32,
   parameter int CP_MAIN = 4,
   parameter int CP_AUX  = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cmd_valid,
   input logic [3:0]        cmd_cp,
   input logic [2:0]        cmd_kind,
   input logic [31:0]       cmd_instr,
   input logic              cmd_first,
   input logic [2:0]        rsp_code,
   input logic              fiq_n,
   input logic              irq_n,
   input logic [DATA_W-1:0] dly_val
);
   logic is_main, is_aux, is_op, zero_dly;
   logic [3:0] opc;
   assign is_main  = cmd_valid && cmd_cp == 4'(CP_MAIN);
   assign is_aux   = cmd_valid && cmd_cp == 4'(CP_AUX);
   assign is_op    = cmd_kind == 3'd6;
   assign opc      = cmd_instr[23:20];
   assign zero_dly = dly_val[CNT_W-1:0] == '0;

   // R1
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_valid |-> rsp_code == 3'd0);
   // R1
   reset_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (fiq_n && irq_n));
   // R12
   foreign_cp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !is_main && !is_aux) |-> rsp_code == 3'd0);
   // R11
   aux_xfer_cant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (is_aux && cmd_kind >= 3'd2 && cmd_kind <= 3'd5) |-> rsp_code == 3'd3);
   // R11
   main_op_cant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (is_main && is_op && opc != 4'd0) |-> rsp_code == 3'd3);
   // R6
   stall_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((is_main || is_aux) && is_op && opc == 4'd0 && cmd_first && zero_dly)
      |-> rsp_code == 3'd1);
   // R7
   fast_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (is_aux && is_op && opc == 4'd1 && zero_dly) |=> !fiq_n);
   // R7
   norm_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (is_aux && is_op && opc == 4'd2 && zero_dly) |=> !irq_n);
   // R8
   fast_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (is_aux && is_op && opc == 4'd3) |=> fiq_n);
   // R8
   norm_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (is_aux && is_op && opc == 4'd4) |=> irq_n);
endmodule

bind cp_timer_unit cpt_checker #(
   .DATA_W(DATA_W), .CNT_W(CNT_W), .CP_MAIN(CP_MAIN), .CP_AUX(CP_AUX)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_cp(cmd_cp),
   .cmd_kind(cmd_kind), .cmd_instr(cmd_instr), .cmd_first(cmd_first),
   .rsp_code(rsp_code), .fiq_n(fiq_n), .irq_n(irq_n), .dly_val(rd_b)
);

// File: tb/tb_cp_timer_unit.sv
`timescale 1ns/1ps
module tb_cp_timer_unit;
   localparam logic [2:0] NONE = 3'd0, DONE = 3'd1, BUSY = 3'd2, CANT = 3'd3, MORE = 3'd4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic [3:0]  cmd_cp = '0;
   logic [2:0]  cmd_kind = '0;
   logic [31:0] cmd_instr = '0;
   logic [31:0] cmd_wdata = '0;
   logic        cmd_first = 1'b0;
   logic [31:0] cyc = '0;
   logic [2:0]  rsp_code;
   logic [31:0] rsp_rdata;
   logic        fiq_n, irq_n;

   int nchk = 0, nfail = 0;
   logic [2:0]  r_code;
   logic [31:0] r_data, r_cyc;
   logic [31:0] mdl [16];

   always #2 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 32'd1;

   cp_timer_unit dut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_cp(cmd_cp),
      .cmd_kind(cmd_kind), .cmd_instr(cmd_instr), .cmd_wdata(cmd_wdata),
      .cmd_first(cmd_first), .cycle_cnt(cyc), .rsp_code(rsp_code),
      .rsp_rdata(rsp_rdata), .fiq_n(fiq_n), .irq_n(irq_n)
   );

   function automatic logic [31:0] f_move(int idx);
      return 32'(idx & 15) << 16;
   endfunction
   function automatic logic [31:0] f_xfer(int idx, bit lng);
      return (32'(lng) << 22) | (32'(idx & 15) << 12);
   endfunction
   function automatic logic [31:0] f_op(int opc, int opr);
      return (32'(opc & 15) << 20) | 32'(opr & 15);
   endfunction
   function automatic logic [3:0] f_foreign();
      logic [3:0] c;
      c = 4'($urandom_range(0, 13));
      return (c >= 4'd4) ? c + 4'd2 : c;
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic issue(logic [3:0] cp, logic [2:0] kind, logic [31:0] ins,
                        logic [31:0] wd, logic first);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_cp = cp; cmd_kind = kind;
      cmd_instr = ins; cmd_wdata = wd; cmd_first = first;
      #1;
      r_code = rsp_code; r_data = rsp_rdata; r_cyc = cyc;
      @(posedge clk);
      #1 cmd_valid = 1'b0;
   endtask

   task automatic wr(int cp, int idx, logic [31:0] v);
      issue(4'(cp), 3'd0, f_move(idx), v, 1'b0);
      mdl[idx] = v;
   endtask

   task automatic readback(string req);
      for (int i = 0; i < 16; i++) begin
         issue(4'd4, 3'd1, f_move(i), 32'h0, 1'b0);
         check(req, r_data, mdl[i]);
      end
   endtask

   task automatic wait_edges(int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      nfail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

   initial begin : main
      int busies;
      logic [31:0] v;
      v = $urandom(32'h5EED_0042);
      for (int i = 0; i < 16; i++) mdl[i] = '0;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      #1;
      check("R1 idle response", 32'(rsp_code), 32'(NONE));
      check("R1 fiq_n", 32'(fiq_n), 1);
      check("R1 irq_n", 32'(irq_n), 1);
      readback("R1 reset register");

      // R2 directed: write via main, read via aux
      wr(4, 3, 32'hA5A5_0003);
      check("R2 write done", 32'(r_code), 32'(DONE));
      issue(4'd5, 3'd1, f_move(3), 32'h0, 1'b0);
      check("R2 read done", 32'(r_code), 32'(DONE));
      check("R2 read data", r_data, 32'hA5A5_0003);

      // random mix
      for (int n = 0; n < 400; n++) begin
         int sel = $urandom_range(0, 7);
         int idx = $urandom_range(0, 15);
         logic [31:0] d = $urandom();
         case (sel)
            0: begin
               wr($urandom_range(4, 5), idx, d);
               check("R2 rand write", 32'(r_code), 32'(DONE));
            end
            1: begin
               issue(4'($urandom_range(4, 5)), 3'd1, f_move(idx), 32'h0, 1'b0);
               check("R2 rand read", r_data, mdl[idx]);
            end
            2: begin
               issue(4'd4, 3'd4, f_xfer(idx, 1'b0), d, 1'b0);
               mdl[idx] = d;
               check("R3 short load", 32'(r_code), 32'(DONE));
            end
            3: begin
               issue(4'd4, 3'd5, f_xfer(idx, 1'b0), 32'h0, 1'b0);
               check("R3 short store rsp", 32'(r_code), 32'(DONE));
               check("R3 short store data", r_data, mdl[idx]);
            end
            4: begin
               issue(f_foreign(), 3'($urandom_range(0, 7)), d, d, 1'b1);
               check("R12 foreign response", 32'(r_code), 32'(NONE));
            end
            5: begin
               issue(4'd4, 3'd6, f_op($urandom_range(1, 15), idx), d, 1'b1);
               check("R11 main opcode cant", 32'(r_code), 32'(CANT));
            end
            6: begin
               if (idx[0])
                  issue(4'd5, 3'd6, f_op($urandom_range(6, 15), idx), d, 1'b1);
               else
                  issue(4'd5, 3'($urandom_range(2, 5)), d & 32'hFFBF_FFFF, d, 1'b0);
               check("R11 aux cant", 32'(r_code), 32'(CANT));
            end
            default: begin
               issue(4'd5, 3'd6, f_op(5, idx), 32'h0, 1'b1);
               mdl[idx] = r_cyc;
               check("R10 stamp rsp", 32'(r_code), 32'(DONE));
            end
         endcase
      end
      readback("R12 R2 R10 readback");
      check("R11 fiq untouched", 32'(fiq_n), 1);
      check("R11 irq untouched", 32'(irq_n), 1);

      // R4 long load and store
      issue(4'd4, 3'd2, f_xfer(7, 1'b1), 32'h0, 1'b0);
      check("R3 load start", 32'(r_code), 32'(DONE));
      for (int w = 0; w < 5; w++) begin
         issue(4'd4, 3'd4, f_xfer(7, 1'b1), 32'h7000_0000 + 32'(w), 1'b0);
         check("R4 long load word", 32'(r_code), 32'((w == 4) ? DONE : MORE));
      end
      mdl[7] = 32'h7000_0004;
      issue(4'd4, 3'd3, f_xfer(7, 1'b1), 32'h0, 1'b0);
      check("R3 store start", 32'(r_code), 32'(DONE));
      for (int w = 0; w < 5; w++) begin
         issue(4'd4, 3'd5, f_xfer(7, 1'b1), 32'h0, 1'b0);
         check("R4 long store word", 32'(r_code), 32'((w == 4) ? DONE : MORE));
         check("R4 long store data", r_data, mdl[7]);
      end

      // R5 restart mid-burst
      issue(4'd4, 3'd2, f_xfer(8, 1'b1), 32'h0, 1'b0);
      for (int w = 0; w < 2; w++) begin
         issue(4'd4, 3'd4, f_xfer(8, 1'b1), 32'h8000_0000 + 32'(w), 1'b0);
         check("R5 partial burst", 32'(r_code), 32'(MORE));
      end
      mdl[8] = 32'h8000_0001;
      issue(4'd4, 3'd3, f_xfer(8, 1'b1), 32'h0, 1'b0);
      for (int w = 0; w < 5; w++) begin
         issue(4'd4, 3'd5, f_xfer(8, 1'b1), 32'h0, 1'b0);
         check("R5 restarted burst", 32'(r_code), 32'((w == 4) ? DONE : MORE));
      end

      // R6 stall lengths
      foreach (mdl[k]) begin end
      for (int t = 0; t < 3; t++) begin
         int dd = (t == 0) ? 5 : (t == 1) ? 1 : 0;
         wr(4, 2, 32'(dd));
         busies = 0;
         issue(4'(4 + (t & 1)), 3'd6, f_op(0, 2), 32'h0, 1'b1);
         while (r_code == BUSY && busies < 50) begin
            busies++;
            issue(4'(4 + (t & 1)), 3'd6, f_op(0, 2), 32'h0, 1'b0);
         end
         check("R6 stall busy count", 32'(busies), 32'(dd));
         check("R6 stall final", 32'(r_code), 32'(DONE));
      end

      // R7 timed fast interrupt, delay 6
      wr(5, 9, 32'd6);
      issue(4'd5, 3'd6, f_op(1, 9), 32'h0, 1'b1);
      check("R7 schedule rsp", 32'(r_code), 32'(DONE));
      wait_edges(5);
      check("R7 fiq before deadline", 32'(fiq_n), 1);
      wait_edges(1);
      check("R7 fiq at deadline", 32'(fiq_n), 0);
      issue(4'd5, 3'd6, f_op(3, 9), 32'h0, 1'b1);
      check("R8 fiq release", 32'(fiq_n), 1);

      // R7 zero delay on normal line
      wr(5, 0, 32'd0);
      issue(4'd5, 3'd6, f_op(2, 0), 32'h0, 1'b1);
      check("R7 irq zero delay", 32'(irq_n), 0);
      issue(4'd5, 3'd6, f_op(4, 0), 32'h0, 1'b1);
      check("R8 irq release", 32'(irq_n), 1);

      // R8 release leaves countdown running
      wr(5, 9, 32'd4);
      issue(4'd5, 3'd6, f_op(2, 9), 32'h0, 1'b1);
      issue(4'd5, 3'd6, f_op(4, 9), 32'h0, 1'b1);
      wait_edges(2);
      check("R8 irq still high", 32'(irq_n), 1);
      wait_edges(1);
      check("R8 countdown survives release", 32'(irq_n), 0);
      issue(4'd5, 3'd6, f_op(4, 9), 32'h0, 1'b1);

      // R9 reschedule from short to long
      wr(5, 10, 32'd3);
      wr(5, 11, 32'd8);
      issue(4'd5, 3'd6, f_op(1, 10), 32'h0, 1'b1);
      issue(4'd5, 3'd6, f_op(1, 11), 32'h0, 1'b1);
      wait_edges(7);
      check("R9 old deadline ignored", 32'(fiq_n), 1);
      wait_edges(1);
      check("R9 new deadline", 32'(fiq_n), 0);
      issue(4'd5, 3'd6, f_op(3, 0), 32'h0, 1'b1);

      // R10 directed stamp
      issue(4'd5, 3'd6, f_op(5, 12), 32'h0, 1'b1);
      mdl[12] = r_cyc;
      issue(4'd4, 3'd1, f_move(12), 32'h0, 1'b0);
      check("R10 stamp value", r_data, mdl[12]);

      // R11 main opcode 1 leaves line alone; R12 foreign schedule ignored
      issue(4'd4, 3'd6, f_op(1, 0), 32'h0, 1'b1);
      check("R11 cant rsp", 32'(r_code), 32'(CANT));
      check("R11 fiq unchanged", 32'(fiq_n), 1);
      issue(4'd15, 3'd6, f_op(2, 0), 32'h0, 1'b1);
      check("R12 foreign rsp", 32'(r_code), 32'(NONE));
      check("R12 irq unchanged", 32'(irq_n), 1);
      issue(4'd0, 3'd0, f_move(3), 32'hDEAD_BEEF, 1'b0);
      readback("R12 foreign write ignored");

      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end
endmodule